// File: doc/BRIEF.md
# Three-Level PWM Gate Sequencer

This block sits between a PWM decoder and the two gate drivers of a synchronous buck stage. It takes a two-bit command that selects high, low or mid level. From it the block produces a high-side and a low-side gate enable, and it never lets both enables be on together. Before it turns a switch on, it waits for the other gate to be sensed off and then waits a set number of dead-time cycles. A turn-on on the low-side path also waits for the switch node to be sensed low. A timeout covers the case where that flag never arrives.

The mid level selects diode emulation. The high side is turned off and the low side is turned on after the dead time. The low side then stays on through a blanking window in which the zero-cross flag has no effect. After the window, the first zero cross turns the low side off. A supervisor drive-enable forces both enables low while it is deasserted. When the enable returns, the sequence starts again from the current command. All analog sensing arrives as synchronous flags, and every duration is a cycle count set by a parameter.

Top module: `tri_pwm_deadtime`

## Requirements
- R1: While `rst` is high, both gate enables are low. They stay low for at least one cycle after reset is released.
- R2: When `drv_en` is sampled low, both enables are low after that edge. When `drv_en` is sampled high again at edge e, the command is sequenced from its entry state. For the low command, with both sense flags already high, the low side turns on at edge e+1+NOVL_CYC.
- R3: The two enables are never high in the same cycle. An enable rises only when the other enable was low in the cycle before.
- R4: Let edge c be the first edge that samples code 2'b10. The low side goes off at edge c+1. If `ls_gate_off` is first sampled high at edge c+s (s >= 0), the high side turns on at edge c+max(2,s)+NOVL_CYC.
- R5: Let edge c be the first edge that samples code 2'b00. The high side goes off at edge c+1. If `hs_gate_off` and `sw_node_low` are both first sampled high at edge c+s, the low side turns on at edge c+min(max(2,s)+NOVL_CYC, TOUT_CYC+1).
- R6: If the low-side turn-on is not enabled by the switch-node-low flag, the low side turns on at edge c+TOUT_CYC+1 anyway, counted from the edge c that sampled code 2'b00.
- R7: Let edge c be the first edge that samples a mid code. The high side goes off at edge c+1. If `hs_gate_off` is first sampled high at edge c+s, the low side turns on at edge c+r, where r = max(2,s)+NOVL_CYC.
- R8: In mid mode, the low side stays on through the BLANK_CYC cycles that follow its turn-on, whatever `zero_cross` does. It also stays on in the first monitoring cycle after them.
- R9: In mid mode, if `zero_cross` is first sampled high at edge c+z, the low side turns off at edge c+max(r+BLANK_CYC+1, z). It stays off until the command changes.
- R10: The code mapping is 2'b00 low, 2'b01 mid, 2'b10 high and 2'b11 mid. A switch between 2'b01 and 2'b11 is not a change of command and restarts nothing.
- R11: A change of command while a sequence is pending drops the pending timers. The new command starts from its own entry state one edge after the new code is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_code | input | 2 | Three-level PWM command code |
| drv_en | input | 1 | Drive enable from the supervisor |
| hs_gate_off | input | 1 | High-side gate sensed off |
| ls_gate_off | input | 1 | Low-side gate sensed off |
| sw_node_low | input | 1 | Switch node sensed low |
| zero_cross | input | 1 | Zero-cross comparator flag |
| hs_gate_en | output | 1 | High-side gate enable (registered) |
| ls_gate_en | output | 1 | Low-side gate enable (registered) |

## Verification
Every result is a fixed edge count after the edge that samples the new code. The outgoing enable drops one edge later. The incoming enable rises max(2,s)+NOVL_CYC edges later. A timeout turn-on comes TOUT_CYC+1 edges later. A zero-cross turn-off comes at the later of blank-end-plus-one and the edge that samples the flag. The bench drives each stimulus on a falling edge and numbers the falling edges that follow it. It computes the index where each enable is due from these formulas, and it records the first index where the enable actually moves. Sweeps over the arrival cycle of each sense flag show that every clamp in the formulas is reached: the dead-time floor, the timeout ceiling and the blanking floor.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'd0,
    CMD_MID  = 2'd1,
    CMD_HIGH = 2'd2
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_H_WAIT,
    ST_H_NOVL,
    ST_H_ON,
    ST_L_WAIT,
    ST_L_NOVL,
    ST_L_ON,
    ST_M_WAIT,
    ST_M_NOVL,
    ST_M_BLANK,
    ST_M_ZCD,
    ST_M_DONE
  } seq_e;

  // timer slots
  localparam int unsigned T_NOV  = 0;
  localparam int unsigned T_BLK  = 1;
  localparam int unsigned T_TO   = 2;
  localparam int unsigned N_TMR  = 3;

  function automatic cmd_e decode_code(input logic [1:0] code);
    case (code)
      2'b00:   return CMD_LOW;
      2'b10:   return CMD_HIGH;
      default: return CMD_MID;
    endcase
  endfunction

  function automatic seq_e entry_of(input cmd_e c);
    case (c)
      CMD_HIGH: return ST_H_WAIT;
      CMD_LOW:  return ST_L_WAIT;
      default:  return ST_M_WAIT;
    endcase
  endfunction

endpackage

// File: rtl/tpd_cmd_decode.sv
module tpd_cmd_decode
  import tpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwm_code,
  output cmd_e       cmd
);

  always_ff @(posedge clk) begin
    if (rst) cmd <= CMD_LOW;
    else     cmd <= decode_code(pwm_code);
  end

  // R10: both mid encodings land on the same command
  a_r10_mid_alias: assert property (@(posedge clk) disable iff (rst)
    (pwm_code[0] && $past(pwm_code[0]) && !rst) |=> $stable(cmd));

endmodule

// File: rtl/tpd_timer.sv
module tpd_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R4: dead-time count never stalls or skips while running
  a_r4_timer_step: assert property (@(posedge clk) disable iff (rst)
    (!load && !done) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/tpd_seq.sv
module tpd_seq
  import tpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              drv_en,
  input  cmd_e              cmd,
  input  logic              hs_off,
  input  logic              ls_off,
  input  logic              sw_low,
  input  logic              zc,
  input  logic [N_TMR-1:0]  t_done,
  output logic [N_TMR-1:0]  t_load,
  output logic              hs_en,
  output logic              ls_en
);

  seq_e state, nxt;
  cmd_e cur;
  logic synced;
  logic steady;

  assign steady = drv_en && synced && (cmd == cur);

  always_comb begin
    nxt = state;
    if (!drv_en) begin
      nxt = ST_IDLE;
    end else if (!synced || (cmd != cur)) begin
      nxt = entry_of(cmd);
    end else begin
      case (state)
        ST_IDLE:    nxt = entry_of(cmd);
        ST_H_WAIT:  if (ls_off) nxt = ST_H_NOVL;
        ST_H_NOVL:  if (t_done[T_NOV]) nxt = ST_H_ON;
        ST_L_WAIT: begin
          if (t_done[T_TO])           nxt = ST_L_ON;
          else if (hs_off && sw_low)  nxt = ST_L_NOVL;
        end
        ST_L_NOVL:  if (t_done[T_NOV] || t_done[T_TO]) nxt = ST_L_ON;
        ST_M_WAIT:  if (hs_off) nxt = ST_M_NOVL;
        ST_M_NOVL:  if (t_done[T_NOV]) nxt = ST_M_BLANK;
        ST_M_BLANK: if (t_done[T_BLK]) nxt = ST_M_ZCD;
        ST_M_ZCD:   if (zc) nxt = ST_M_DONE;
        default:    nxt = state;
      endcase
    end
  end

  always_comb begin
    t_load        = '0;
    t_load[T_NOV] = (state != nxt) &&
                    ((nxt == ST_H_NOVL) || (nxt == ST_L_NOVL) || (nxt == ST_M_NOVL));
    t_load[T_BLK] = (state != nxt) && (nxt == ST_M_BLANK);
    t_load[T_TO]  = (state != nxt) && (nxt == ST_L_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cur    <= CMD_LOW;
      synced <= 1'b0;
      hs_en  <= 1'b0;
      ls_en  <= 1'b0;
    end else begin
      state  <= nxt;
      synced <= drv_en;
      if (drv_en) cur <= cmd;
      hs_en  <= (nxt == ST_H_ON);
      ls_en  <= (nxt == ST_L_ON) || (nxt == ST_M_BLANK) || (nxt == ST_M_ZCD);
    end
  end

  // R3: no shoot-through
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  // R3: break before make on each side
  a_r3_hs_after_ls_off: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> !$past(ls_en));
  a_r3_ls_after_hs_off: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> !$past(hs_en));

  // R2: supervisor disable clears both enables at the next edge
  a_r2_disable: assert property (@(posedge clk) disable iff (rst)
    !drv_en |=> (!hs_en && !ls_en));

  // R8: blanking keeps the low side on regardless of zero cross
  a_r8_blank_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_M_BLANK && steady) |=> ls_en);

  // R6: an expired timeout in the low path forces the low side on
  a_r6_timeout_on: assert property (@(posedge clk) disable iff (rst)
    (state == ST_L_WAIT && t_done[T_TO] && steady) |=> ls_en);

  // R9: after a zero cross the low side stays off while the command holds
  a_r9_done_off: assert property (@(posedge clk) disable iff (rst)
    (state == ST_M_DONE && steady) |=> !ls_en);

endmodule

// File: rtl/tri_pwm_deadtime.sv
module tri_pwm_deadtime
  import tpd_pkg::*;
#(
  parameter int unsigned NOVL_CYC  = 4,
  parameter int unsigned BLANK_CYC = 16,
  parameter int unsigned TOUT_CYC  = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwm_code,
  input  logic       drv_en,
  input  logic       hs_gate_off,
  input  logic       ls_gate_off,
  input  logic       sw_node_low,
  input  logic       zero_cross,
  output logic       hs_gate_en,
  output logic       ls_gate_en
);

  localparam int unsigned DUR_A   = (NOVL_CYC > BLANK_CYC) ? NOVL_CYC : BLANK_CYC;
  localparam int unsigned DUR_MAX = (DUR_A > TOUT_CYC) ? DUR_A : TOUT_CYC;
  localparam int unsigned TW      = (DUR_MAX > 1) ? $clog2(DUR_MAX) : 1;
  localparam int unsigned DUR [N_TMR] = '{NOVL_CYC, BLANK_CYC, TOUT_CYC};

  cmd_e             cmd;
  logic [N_TMR-1:0] t_load;
  logic [N_TMR-1:0] t_done;

  tpd_cmd_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .pwm_code (pwm_code),
    .cmd      (cmd)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    tpd_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load[g]),
      .load_val (TW'(DUR[g] - 1)),
      .done     (t_done[g])
    );
  end

  tpd_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .drv_en (drv_en),
    .cmd    (cmd),
    .hs_off (hs_gate_off),
    .ls_off (ls_gate_off),
    .sw_low (sw_node_low),
    .zc     (zero_cross),
    .t_done (t_done),
    .t_load (t_load),
    .hs_en  (hs_gate_en),
    .ls_en  (ls_gate_en)
  );

  // R1: reset clears both enables
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!hs_gate_en && !ls_gate_en));

endmodule

// File: tb/sim_tri_pwm_deadtime.sv
module sim_tri_pwm_deadtime;
  localparam int NV = 2;
  localparam int BK = 3;
  localparam int TO = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv_en = 1'b0;
  logic [1:0] pwm = 2'b00;
  logic hs_off = 1'b0, ls_off = 1'b0, sw_low = 1'b0, zc = 1'b0;
  logic hs_en, ls_en;
  int vec = 0, bad = 0, overlap = 0;

  always #5 clk = ~clk;

  tri_pwm_deadtime #(.NOVL_CYC(NV), .BLANK_CYC(BK), .TOUT_CYC(TO)) u0 (
    .clk(clk), .rst(rst), .pwm_code(pwm), .drv_en(drv_en),
    .hs_gate_off(hs_off), .ls_gate_off(ls_off), .sw_node_low(sw_low),
    .zero_cross(zc), .hs_gate_en(hs_en), .ls_gate_en(ls_en)
  );

  function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int imin(input int a, input int b); return (a < b) ? a : b; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (hs_en && ls_en) overlap++;
  endtask

  task automatic settle(input logic [1:0] code);
    pwm = code; hs_off = 1; ls_off = 1; sw_low = 1; zc = 0; drv_en = 1;
    repeat (NV + BK + TO + 6) step();
  endtask

  // R4: high path with the low-side-off flag arriving at falling edge j
  task automatic t_high(input int j);
    int f = -1, r = -1;
    settle(2'b00);
    pwm = 2'b10; ls_off = (j == 0);
    for (int i = 1; i <= 30; i++) begin
      step();
      if (!ls_en && f < 0) f = i;
      if (hs_en && r < 0) r = i;
      if (i == j) ls_off = 1;
    end
    check(f == 2, "R4", f, 2);
    check(r == imax(3, j + 1) + NV, "R4", r, imax(3, j + 1) + NV);
  endtask

  // R5 / R6: low path; both=0 means the switch node never reads low
  task automatic t_low(input int j, input bit both);
    int f = -1, r = -1, e;
    settle(2'b10);
    pwm = 2'b00; hs_off = (j == 0); sw_low = both && (j == 0);
    for (int i = 1; i <= 30; i++) begin
      step();
      if (!hs_en && f < 0) f = i;
      if (ls_en && r < 0) r = i;
      if (i == j) begin hs_off = 1; if (both) sw_low = 1; end
    end
    e = both ? imin(imax(3, j + 1) + NV, TO + 2) : TO + 2;
    check(f == 2, "R5", f, 2);
    check(r == e, (e == TO + 2) ? "R6" : "R5", r, e);
  endtask

  // R7 / R8 / R9 / R10: mid path; swap flips 01<->11 during blanking
  task automatic t_mid(input int j, input int z, input logic [1:0] code, input bit swap);
    int hf = -1, r = -1, f = -1, relit = 0, er, ef;
    settle(2'b10);
    pwm = code; hs_off = (j == 0); zc = (z == 0);
    er = imax(3, j + 1) + NV;
    ef = imax(er + BK + 1, z + 1);
    for (int i = 1; i <= 40; i++) begin
      step();
      if (!hs_en && hf < 0) hf = i;
      if (ls_en && r < 0) r = i;
      if (!ls_en && r > 0 && f < 0) f = i;
      if (ls_en && f > 0) relit++;
      if (i == j) hs_off = 1;
      if (i == z) zc = 1;
      if (swap && i == er) pwm = code ^ 2'b10;
    end
    check(hf == 2, "R7", hf, 2);
    check(r == er, (code == 2'b11) ? "R10" : "R7", r, er);
    check(f == ef, (z <= er + BK) ? "R8" : "R9", f, ef);
    check(relit == 0, "R9", relit, 0);
    if (swap) check(f == ef, "R10", f, ef);
  endtask

  // R11: abort a pending high-side turn-on with a low command
  task automatic t_abort_high();
    int hs_seen = 0, r = -1;
    settle(2'b00);
    pwm = 2'b10;
    for (int i = 1; i <= 30; i++) begin
      step();
      if (hs_en) hs_seen++;
      if (ls_en && i > 2 && r < 0) r = i;
      if (i == 3) pwm = 2'b00;
    end
    check(hs_seen == 0, "R11", hs_seen, 0);
    check(r == 6 + NV, "R11", r, 6 + NV);
  endtask

  // R11: abort mid-mode blanking with a high command
  task automatic t_abort_mid();
    int f = -1, r = -1, er;
    settle(2'b10);
    pwm = 2'b01;
    er = 3 + NV;
    for (int i = 1; i <= 30; i++) begin
      step();
      if (i > er && !ls_en && f < 0) f = i;
      if (i > er && hs_en && r < 0) r = i;
      if (i == er + 1) pwm = 2'b10;
    end
    check(f == er + 3, "R11", f, er + 3);
    check(r == er + 4 + NV, "R11", r, er + 4 + NV);
  endtask

  // R2: disable from high, switch to low while disabled, re-enable at edge j
  task automatic t_enable(input int j);
    int early = 0, r = -1, h1 = -1;
    settle(2'b10);
    drv_en = 0;
    for (int i = 1; i <= 30; i++) begin
      step();
      if (i == 1) h1 = hs_en;
      if (ls_en && r < 0) r = i;
      if (i < j + 2 + NV && (hs_en || ls_en)) early++;
      if (i == 1) pwm = 2'b00;
      if (i == j) drv_en = 1;
    end
    check(h1 == 0, "R2", h1, 0);
    check(early == 0, "R2", early, 0);
    check(r == j + 2 + NV, "R2", r, j + 2 + NV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int r = -1, any = 0;
    pwm = 2'b10; drv_en = 1; hs_off = 1; ls_off = 1; sw_low = 1;
    repeat (4) begin
      step();
      if (hs_en || ls_en) any++;
    end
    check(any == 0, "R1", any, 0);
    rst = 0;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (i == 1) check(!hs_en && !ls_en, "R1", {hs_en, ls_en}, 0);
      if (hs_en && r < 0) r = i;
    end
    check(r == 3 + NV, "R1", r, 3 + NV);

    for (int j = 0; j <= 5; j++) t_high(j);
    for (int j = 0; j <= 8; j++) t_low(j, 1'b1);
    t_low(99, 1'b1);
    for (int j = 0; j <= 4; j++) t_low(j, 1'b0);
    for (int j = 0; j <= 4; j++)
      for (int z = 0; z <= 14; z += 2) begin
        t_mid(j, z, 2'b01, 1'b0);
        t_mid(j, z, 2'b11, 1'b0);
      end
    t_mid(0, 0, 2'b01, 1'b1);
    t_mid(2, 12, 2'b11, 1'b1);
    t_abort_high();
    t_abort_mid();
    t_enable(2);
    t_enable(3);
    t_enable(5);

    check(overlap == 0, "R3", overlap, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule